// File: doc/BRIEF.md
# Micro Translation Front Buffer with Refill

This block is a small, fully associative translation buffer placed ahead of a larger main translation table. A requester presents a virtual page number together with the current process identifier. When a stored entry matches, the block returns the physical frame number and the read, write and execute permissions in the same cycle.

When no entry matches, the block raises a stall and queries the main table through a request/valid handshake. A positive answer from the main table is passed straight to the requester and is copied into the buffer. Empty slots are filled first. Once every slot is occupied, the least recently used entry is overwritten. A negative answer is returned as a miss exception that carries the faulting page number, and nothing is stored.

Software cannot see the buffer. It is cleared whenever the translation table is written or the process-identifier control register is written, so its contents always stay a subset of the main table.

Top module: `xlat_front_buf`

## Requirements
- R1: After reset every entry is invalid. With `req_valid_i` low, `resp_valid_o`, `stall_o` and `mt_req_o` are 0. The first lookup misses.
- R2: A lookup hits when an entry is valid, its page number equals `req_vpn_i`, and either its stored identifier equals `pid_i` or its global bit is set. On a hit, `resp_valid_o` is 1 in the same cycle, together with the stored `resp_pfn_o` and `resp_perm_o`, and `stall_o` is 0.
- R3: On a miss while idle, `stall_o` is 1 and `resp_valid_o` is 0 in that cycle. From the next cycle, `mt_req_o` is 1 with `mt_vpn_o` and `mt_pid_o` holding the missed request, and it stays asserted until `mt_valid_i`. The requester holds its request until `resp_valid_o`.
- R4: When `mt_valid_i` arrives with `mt_hit_i`=1, `resp_valid_o` is 1 in that cycle with `resp_exc_o`=0 and the returned frame and permissions. The entry is installed, so the same lookup afterwards hits.
- R5: When `mt_valid_i` arrives with `mt_hit_i`=0, `resp_valid_o` and `resp_exc_o` are 1 in that cycle and `exc_vpn_o` equals the missed page number. No entry is installed, so a repeat of the lookup misses again.
- R6: While any entry is invalid, a refill goes into the lowest-indexed invalid entry and no valid entry is displaced.
- R7: When all entries are valid, a refill replaces the entry whose last hit or install is oldest. Both hits and installs count as use.
- R8: A cycle with `tbl_wr_i`=1 invalidates every entry from the next cycle.
- R9: A cycle with `pid_wr_i`=1 invalidates every entry from the next cycle.
- R10: If a flush occurs in any cycle from the miss through the cycle `mt_valid_i` returns, the returned entry is still passed to the requester but is not installed.
- R11: An entry whose global bit is set hits for every value of `pid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_vpn_i | input | VPN_W | Virtual page number to translate |
| pid_i | input | PID_W | Current process identifier |
| resp_valid_o | output | 1 | Response delivered this cycle |
| resp_exc_o | output | 1 | Response is a miss exception |
| resp_pfn_o | output | PFN_W | Physical frame number |
| resp_perm_o | output | 3 | Permissions {x, w, r} |
| exc_vpn_o | output | VPN_W | Faulting page number for an exception |
| stall_o | output | 1 | Request present but not yet answered |
| mt_req_o | output | 1 | Main-table query pending |
| mt_vpn_o | output | VPN_W | Page number sent to the main table |
| mt_pid_o | output | PID_W | Identifier sent to the main table |
| mt_valid_i | input | 1 | Main-table answer present |
| mt_hit_i | input | 1 | Main table holds the translation |
| mt_global_i | input | 1 | Returned entry is global |
| mt_pfn_i | input | PFN_W | Returned frame number |
| mt_perm_i | input | 3 | Returned permissions {x, w, r} |
| tbl_wr_i | input | 1 | Translation-table write, flush |
| pid_wr_i | input | 1 | Identifier-register write, flush |

## Verification
A hit is due in the same cycle as the request, so the bench samples one nanosecond after it drives inputs at the falling edge. A miss shows `stall_o` in that same sample, and `mt_req_o` is checked one falling edge later, which is one register stage away. The refill or exception response is checked in the cycle the bench raises `mt_valid_i`. An install or a flush only becomes visible after the next rising edge, so each is checked by a later lookup and never in the cycle it happens. A timestamp model in the bench predicts hits, victims and flush effects across random page and identifier traffic and random handshake delays.

// File: rtl/xfb_pkg.sv
package xfb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } xfb_state_e;

  typedef logic [2:0] perm_t;  // {x, w, r}
endpackage

// File: rtl/xfb_lru.sv
module xfb_lru #(
  parameter int N  = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  vld_i,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic [IW-1:0] victim_o
);
  // age 0 = most recent, N-1 = least recent; ages stay a permutation
  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx_i)                 age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i])    age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  logic found;
  always_comb begin
    victim_o = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && !vld_i[i]) begin
        victim_o = IW'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] == IW'(N-1)) victim_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xfb_store.sv
module xfb_store
  import xfb_pkg::*;
#(
  parameter int N     = 6,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PFN_W = 20,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [PID_W-1:0] lk_pid_i,
  output logic [N-1:0]     hit_vec_o,
  output logic [N-1:0]     vld_o,
  output logic [IW-1:0]    hit_idx_o,
  output logic [PFN_W-1:0] hit_pfn_o,
  output perm_t            hit_perm_o,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic             wr_glb_i,
  input  logic [PFN_W-1:0] wr_pfn_i,
  input  perm_t            wr_perm_i
);
  logic [VPN_W-1:0] vpn_q  [N];
  logic [PID_W-1:0] pid_q  [N];
  logic [PFN_W-1:0] pfn_q  [N];
  perm_t            perm_q [N];
  logic [N-1:0]     glb_q;
  logic [N-1:0]     vld_q;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        glb_q[g]  <= 1'b0;
        vpn_q[g]  <= '0;
        pid_q[g]  <= '0;
        pfn_q[g]  <= '0;
        perm_q[g] <= '0;
      end else if (flush_i) begin
        vld_q[g]  <= 1'b0;  // flush beats a same-cycle install
      end else if (wr_i && wr_idx_i == IW'(g)) begin
        vld_q[g]  <= 1'b1;
        glb_q[g]  <= wr_glb_i;
        vpn_q[g]  <= wr_vpn_i;
        pid_q[g]  <= wr_pid_i;
        pfn_q[g]  <= wr_pfn_i;
        perm_q[g] <= wr_perm_i;
      end
    end

    assign hit_vec_o[g] = vld_q[g] && (vpn_q[g] == lk_vpn_i) &&
                          (glb_q[g] || (pid_q[g] == lk_pid_i));
  end

  assign vld_o = vld_q;

  always_comb begin
    hit_idx_o  = '0;
    hit_pfn_o  = '0;
    hit_perm_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec_o[i]) begin
        hit_idx_o  = hit_idx_o | IW'(i);
        hit_pfn_o  = hit_pfn_o | pfn_q[i];
        hit_perm_o = hit_perm_o | perm_q[i];
      end
    end
  end
endmodule

// File: rtl/xlat_front_buf.sv
module xlat_front_buf
  import xfb_pkg::*;
#(
  parameter int N     = 6,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PFN_W = 20,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [PID_W-1:0] pid_i,
  output logic             resp_valid_o,
  output logic             resp_exc_o,
  output logic [PFN_W-1:0] resp_pfn_o,
  output logic [2:0]       resp_perm_o,
  output logic [VPN_W-1:0] exc_vpn_o,
  output logic             stall_o,
  output logic             mt_req_o,
  output logic [VPN_W-1:0] mt_vpn_o,
  output logic [PID_W-1:0] mt_pid_o,
  input  logic             mt_valid_i,
  input  logic             mt_hit_i,
  input  logic             mt_global_i,
  input  logic [PFN_W-1:0] mt_pfn_i,
  input  logic [2:0]       mt_perm_i,
  input  logic             tbl_wr_i,
  input  logic             pid_wr_i
);
  xfb_state_e       state_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PID_W-1:0] pid_q;
  logic             kill_q;

  logic [N-1:0]     hit_vec, vld_vec;
  logic [IW-1:0]    hit_idx, victim, touch_idx;
  logic [PFN_W-1:0] hit_pfn;
  perm_t            hit_perm;
  logic             hit_any, flush, wr, touch;

  assign hit_any = |hit_vec;
  assign flush   = tbl_wr_i | pid_wr_i;

  xfb_store #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)) u_store (
    .clk_i, .rst_ni,
    .lk_vpn_i  (req_vpn_i),
    .lk_pid_i  (pid_i),
    .hit_vec_o (hit_vec),
    .vld_o     (vld_vec),
    .hit_idx_o (hit_idx),
    .hit_pfn_o (hit_pfn),
    .hit_perm_o(hit_perm),
    .flush_i   (flush),
    .wr_i      (wr),
    .wr_idx_i  (victim),
    .wr_vpn_i  (vpn_q),
    .wr_pid_i  (pid_q),
    .wr_glb_i  (mt_global_i),
    .wr_pfn_i  (mt_pfn_i),
    .wr_perm_i (mt_perm_i)
  );

  xfb_lru #(.N(N)) u_lru (
    .clk_i, .rst_ni,
    .vld_i      (vld_vec),
    .touch_i    (touch),
    .touch_idx_i(touch_idx),
    .victim_o   (victim)
  );

  assign touch_idx = wr ? victim : hit_idx;

  always_comb begin
    resp_valid_o = 1'b0;
    resp_exc_o   = 1'b0;
    resp_pfn_o   = hit_pfn;
    resp_perm_o  = hit_perm;
    wr           = 1'b0;
    touch        = 1'b0;
    if (state_q == ST_IDLE) begin
      if (req_valid_i && hit_any) begin
        resp_valid_o = 1'b1;
        touch        = 1'b1;
      end
    end else if (mt_valid_i) begin
      resp_valid_o = 1'b1;
      resp_pfn_o   = mt_pfn_i;
      resp_perm_o  = mt_perm_i;
      if (!mt_hit_i) begin
        resp_exc_o = 1'b1;
      end else if (!flush && !kill_q) begin
        wr    = 1'b1;
        touch = 1'b1;
      end
    end
  end

  assign stall_o   = req_valid_i && !resp_valid_o;
  assign mt_req_o  = (state_q == ST_WAIT);
  assign mt_vpn_o  = vpn_q;
  assign mt_pid_o  = pid_q;
  assign exc_vpn_o = vpn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      pid_q   <= '0;
      kill_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i && !hit_any) begin
          state_q <= ST_WAIT;
          vpn_q   <= req_vpn_i;
          pid_q   <= pid_i;
          kill_q  <= flush;
        end
        default: begin
          if (flush) kill_q <= 1'b1;
          if (mt_valid_i) state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/xfb_chk.sv
module xfb_chk #(
  parameter int N     = 6,
  parameter int VPN_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [N-1:0]     hit_vec,
  input logic [N-1:0]     vld_vec,
  input logic             mt_req_o,
  input logic             mt_valid_i,
  input logic [VPN_W-1:0] mt_vpn_o,
  input logic             resp_exc_o,
  input logic             tbl_wr_i,
  input logic             pid_wr_i
);
  p_single_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  p_req_from_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mt_req_o) |-> $past(req_valid_i && (hit_vec == '0)));

  p_req_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mt_req_o && !mt_valid_i) |=> (mt_req_o && $stable(mt_vpn_o)));

  p_exc_only_waiting_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_exc_o |-> mt_req_o);

  p_exc_no_install_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_exc_o && !tbl_wr_i && !pid_wr_i) |=> (vld_vec == $past(vld_vec)));

  p_tbl_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_i |=> (vld_vec == '0));

  p_pid_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pid_wr_i |=> (vld_vec == '0));
endmodule

bind xlat_front_buf xfb_chk #(.N(N), .VPN_W(VPN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .hit_vec    (hit_vec),
  .vld_vec    (vld_vec),
  .mt_req_o   (mt_req_o),
  .mt_valid_i (mt_valid_i),
  .mt_vpn_o   (mt_vpn_o),
  .resp_exc_o (resp_exc_o),
  .tbl_wr_i   (tbl_wr_i),
  .pid_wr_i   (pid_wr_i)
);

// File: tb/sim_xlat_front_buf.sv
`timescale 1ns/1ps
module sim_xlat_front_buf;
  localparam int N     = 6;
  localparam int VPN_W = 20;
  localparam int PID_W = 8;
  localparam int PFN_W = 20;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             req_valid = 0, mt_valid = 0, mt_hit = 0, mt_glb = 0;
  logic             tbl_wr = 0, pid_wr = 0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [PID_W-1:0] pid = '0;
  logic [PFN_W-1:0] mt_pfn = '0;
  logic [2:0]       mt_perm = '0;
  logic             resp_valid, resp_exc, stall, mt_req;
  logic [PFN_W-1:0] resp_pfn;
  logic [2:0]       resp_perm;
  logic [VPN_W-1:0] exc_vpn, mt_vpn;
  logic [PID_W-1:0] mt_pid;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  bit obs_hit;

  // reference model: timestamps of last use
  bit m_v[N];
  int m_vpn[N], m_pid[N], m_pfn[N], m_perm[N], m_ts[N];
  bit m_g[N];
  int tnow = 0;

  always #4 clk = ~clk;  // 125 MHz

  xlat_front_buf #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vpn_i(req_vpn), .pid_i(pid),
    .resp_valid_o(resp_valid), .resp_exc_o(resp_exc), .resp_pfn_o(resp_pfn),
    .resp_perm_o(resp_perm), .exc_vpn_o(exc_vpn), .stall_o(stall),
    .mt_req_o(mt_req), .mt_vpn_o(mt_vpn), .mt_pid_o(mt_pid),
    .mt_valid_i(mt_valid), .mt_hit_i(mt_hit), .mt_global_i(mt_glb),
    .mt_pfn_i(mt_pfn), .mt_perm_i(mt_perm),
    .tbl_wr_i(tbl_wr), .pid_wr_i(pid_wr)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  // main table contents
  function automatic bit f_mt_hit(int v);   return (v % 7) != 6; endfunction
  function automatic bit f_mt_glb(int v);   return ((v >> 2) & 3) == 3; endfunction
  function automatic int f_mt_pfn(int v, int p);
    return v * 5 + 1 + (f_mt_glb(v) ? 0 : p * 64);
  endfunction
  function automatic int f_mt_perm(int v, int p);
    return f_mt_glb(v) ? (v % 8) : ((v + p) % 8);
  endfunction

  function automatic int m_find(int v, int p);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == v && (m_g[i] || m_pid[i] == p)) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int best = 0;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 1; i < N; i++) if (m_ts[i] < m_ts[best]) best = i;
    return best;
  endfunction

  function automatic void m_flush();
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endfunction

  task automatic do_flush(input bit use_pid);
    @(negedge clk);
    tbl_wr = !use_pid; pid_wr = use_pid;
    @(negedge clk);
    tbl_wr = 0; pid_wr = 0;
    m_flush();
  endtask

  // fl: 0 none, 1 flush during wait, 2 flush with answer
  task automatic lookup(input int v, input int p, input int fl, input int dly);
    int mi, vi;
    bit kill;
    @(negedge clk);
    req_valid = 1; req_vpn = VPN_W'(v); pid = PID_W'(p);
    #1;
    mi = m_find(v, p);
    obs_hit = resp_valid;
    if (mi >= 0) begin
      chk(resp_valid && !stall, "R2 hit", resp_valid, 1);
      chk(resp_pfn == PFN_W'(m_pfn[mi]), "R2 pfn", resp_pfn, m_pfn[mi]);
      chk(resp_perm == 3'(m_perm[mi]), "R2 perm", resp_perm, m_perm[mi]);
      m_ts[mi] = ++tnow;
      @(negedge clk);
      req_valid = 0;
      return;
    end
    chk(stall && !resp_valid, "R3 miss stall", {resp_valid, stall}, 1);
    @(negedge clk);
    kill = (fl == 1);
    tbl_wr = (fl == 1);
    #1;
    chk(mt_req && mt_vpn == VPN_W'(v) && mt_pid == PID_W'(p), "R3 query", mt_vpn, v);
    if (fl == 1) m_flush();
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      tbl_wr = 0;
      #1;
      chk(stall && mt_req && !resp_valid, "R3 hold", {mt_req, stall}, 3);
    end
    mt_valid = 1; mt_hit = f_mt_hit(v); mt_glb = f_mt_glb(v);
    mt_pfn = PFN_W'(f_mt_pfn(v, p)); mt_perm = 3'(f_mt_perm(v, p));
    if (fl == 2) begin pid_wr = 1; kill = 1; m_flush(); end
    #1;
    if (f_mt_hit(v)) begin
      chk(resp_valid && !resp_exc && !stall, "R4 refill resp", {resp_valid, resp_exc}, 2);
      chk(resp_pfn == PFN_W'(f_mt_pfn(v, p)), "R4 pfn", resp_pfn, f_mt_pfn(v, p));
      if (!kill) begin
        vi = m_victim();
        m_v[vi] = 1; m_vpn[vi] = v; m_pid[vi] = p; m_g[vi] = f_mt_glb(v);
        m_pfn[vi] = f_mt_pfn(v, p); m_perm[vi] = f_mt_perm(v, p); m_ts[vi] = ++tnow;
      end
    end else begin
      chk(resp_valid && resp_exc, "R5 exception", {resp_valid, resp_exc}, 3);
      chk(exc_vpn == VPN_W'(v), "R5 exc vpn", exc_vpn, v);
    end
    @(negedge clk);
    mt_valid = 0; tbl_wr = 0; pid_wr = 0; req_valid = 0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_flush();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!resp_valid && !stall && !mt_req, "R1 reset outputs", {resp_valid, stall, mt_req}, 0);
    lookup(3, 0, 0, 1);
    chk(!obs_hit, "R1 empty after reset", obs_hit, 0);
    lookup(3, 0, 0, 0);
    chk(obs_hit, "R4 installed entry hits", obs_hit, 1);

    // R11 global entry, R2 pid mismatch
    lookup(12, 0, 0, 2);
    lookup(12, 3, 0, 0);
    chk(obs_hit, "R11 global hit other pid", obs_hit, 1);
    lookup(3, 2, 0, 0);
    chk(!obs_hit, "R2 pid mismatch misses", obs_hit, 0);

    // R5 main-table miss, no install
    lookup(6, 1, 0, 1);
    lookup(6, 1, 0, 0);
    chk(!obs_hit, "R5 no install on exception", obs_hit, 0);

    // R8 / R9 flushes
    do_flush(0);
    lookup(3, 0, 0, 0);
    chk(!obs_hit, "R8 table write flush", obs_hit, 0);
    do_flush(1);
    lookup(3, 0, 0, 0);
    chk(!obs_hit, "R9 pid write flush", obs_hit, 0);

    // R6 invalid-first fill
    do_flush(0);
    for (int k = 0; k < 3; k++) lookup(k, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      lookup(k, 0, 0, 0);
      chk(obs_hit, "R6 fill keeps entries", obs_hit, 1);
    end

    // R7 LRU replacement
    do_flush(1);
    for (int k = 0; k < N; k++) lookup(k, 1, 0, 0);
    lookup(0, 1, 0, 0);
    lookup(8, 1, 0, 0);
    lookup(1, 1, 0, 0);
    chk(!obs_hit, "R7 oldest entry evicted", obs_hit, 0);
    lookup(0, 1, 0, 0);
    chk(obs_hit, "R7 refreshed entry kept", obs_hit, 1);

    // R10 flush races
    lookup(9, 1, 2, 0);
    lookup(9, 1, 0, 0);
    chk(!obs_hit, "R10 flush with answer", obs_hit, 0);
    lookup(10, 1, 1, 2);
    lookup(10, 1, 0, 0);
    chk(!obs_hit, "R10 flush during wait", obs_hit, 0);

    // random traffic against the model
    for (int n = 0; n < 500; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 5) do_flush(r[0]);
      else lookup(int'($urandom % 16), int'($urandom % 4),
                  (r < 9) ? 1 : (r < 13) ? 2 : 0, int'($urandom % 3));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule